// File: doc/BRIEF.md
# Hybrid Branch Direction and Target Predictor

This block gives the fetch or decode stage a guess for each branch: whether it will be taken and, if so, the address to fetch next. A lookup presents the branch address and, when decode has already extracted it, a signed displacement. The block answers in the same cycle with a taken flag, a target address and a flag that says whether that target can be used. When the branch later resolves, an update port supplies its address, its real outcome and its real destination, and the block trains itself from that.

Three parts work together. A table of 2-bit up/down counters, selected by the low address bits, tracks how each branch has behaved. A small direct-mapped buffer remembers where recently taken branches went. For a branch whose counter entry has never been trained, a fixed rule decides: a jump to an address not above the branch is treated as a loop and predicted taken, a jump to a higher address is predicted not taken. A taken prediction is only given out when a target is actually known, either from the buffer or from the displacement added to the branch address.

Top module: `bp_hybrid`

## Requirements
- R1: A synchronous active-high reset clears every valid bit in both tables, so that directly after reset no lookup hits the target buffer and every direction comes from the static rule.
- R2: When the direction entry for the lookup address is untrained and a target is known that is at or below the lookup address, the prediction is taken.
- R3: When the direction entry is untrained and the known target is above the lookup address (unsigned compare), the prediction is not taken.
- R4: The direction entry is selected by lookup/update address bits [DIR_K-1:0] (6 bits by default); addresses that share these bits share one counter, and addresses that differ in them do not.
- R5: Each counter is 2 bits, 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken, 11 strongly taken; bit 1 is the trained direction. An update moves it one step toward the outcome and it holds at 11 and 00. An untrained entry is treated as 01 before its first step, and that update marks it trained.
- R6: From a strong state the trained direction changes only after two consecutive opposite outcomes.
- R7: The target buffer has 16 direct-mapped entries indexed by address bits [3:0] and tagged by the remaining upper bits; an entry is written with the destination only when an update reports taken, a not-taken update leaves it unchanged, and a lookup hits only on a matching tag.
- R8: The predicted target is the buffer's target on a hit; otherwise, when a displacement is supplied, it is the lookup address plus the sign-extended 10-bit displacement, modulo 2^16. With neither, the target is flagged unavailable.
- R9: The taken output is high only when the chosen direction is taken and a target is available.
- R10: A lookup in the same cycle as an update sees the table contents from before that update; the update is visible from the next cycle.
- R11: Once an entry is trained, its counter direction replaces the static rule regardless of whether the target lies above or below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W (16) | Branch address to predict |
| lk_disp_vld | input | 1 | A decoded displacement is supplied |
| lk_disp | input | DISP_W (10) | Signed displacement relative to lk_pc |
| pred_taken | output | 1 | Branch predicted taken with a usable target |
| pred_tgt_vld | output | 1 | pred_tgt holds a usable target |
| pred_tgt | output | PC_W (16) | Predicted target address |
| upd_en | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W (16) | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 for taken |
| upd_tgt | input | PC_W (16) | Resolved destination |

## Verification
The assertions assume the update inputs are quiet while reset is high and that the lookup inputs are settled before the rising edge, since the lookup path is purely combinational from registered state. The saturation and write-landing checks compare a table entry one cycle after an update and rely on nothing else touching that index in between, which holds because only one update can occur per cycle. The stimulus keeps upd_en low during reset, changes inputs only on the falling edge, and samples results before the next rising edge, so every same-cycle lookup sees the pre-update contents.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // one saturating step toward the resolved outcome
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_ST)  ? CTR_ST  : cur + 2'd1;
    else       nxt = (cur == CTR_SNT) ? CTR_SNT : cur - 2'd1;
    return nxt;
  endfunction

  // trained direction read from a counter
  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int ENTRIES = 1 << IDX_W;

  ctr_t             ctr_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  // counter the update starts from: untrained entries count as weak not-taken
  ctr_t wr_cur;
  assign wr_cur = vld_q[wr_idx] ? ctr_q[wr_idx] : CTR_WNT;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_WNT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= ctr_step(wr_cur, wr_taken);
      vld_q[wr_idx] <= 1'b1;
    end
  end

  assign rd_vld = vld_q[rd_idx];
  assign rd_ctr = ctr_q[rd_idx];

  // ---- assertion support: remember last written index ----
  logic [IDX_W-1:0] chk_idx;
  always_ff @(posedge clk) chk_idx <= wr_idx;

  a_r5_sat_high: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && wr_cur == CTR_ST) |=> (ctr_q[chk_idx] == CTR_ST));

  a_r5_sat_low: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && wr_cur == CTR_SNT) |=> (ctr_q[chk_idx] == CTR_SNT));

  a_r5_trained_after_update: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[chk_idx]);

  a_r6_one_miss_keeps_taken: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && wr_cur == CTR_ST) |=> ctr_dir(ctr_q[chk_idx]));

  a_r6_one_miss_keeps_not_taken: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && wr_cur == CTR_SNT) |=> !ctr_dir(ctr_q[chk_idx]));

endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
  parameter int PC_W  = 16,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic [PC_W-1:0] rd_tgt,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_tgt
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;

  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  assign rd_idx = rd_pc[IDX_W-1:0];
  assign rd_tag = rd_pc[PC_W-1:IDX_W];
  assign wr_idx = wr_pc[IDX_W-1:0];
  assign wr_tag = wr_pc[PC_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
      end
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt;
    end
  end

  assign rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_tgt = tgt_q[rd_idx];

  // ---- assertion support ----
  logic [IDX_W-1:0] chk_idx;
  logic [TAG_W-1:0] chk_tag;
  logic [PC_W-1:0]  chk_tgt;
  always_ff @(posedge clk) begin
    chk_idx <= wr_idx;
    chk_tag <= wr_tag;
    chk_tgt <= wr_tgt;
  end

  a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (vld_q[chk_idx] && tag_q[chk_idx] == chk_tag && tgt_q[chk_idx] == chk_tgt));

  a_r7_idle_keeps_entry: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(vld_q));

endmodule

// File: rtl/bp_static_rule.sv
module bp_static_rule #(
  parameter int PC_W = 16
) (
  input  logic [PC_W-1:0] br_pc,
  input  logic [PC_W-1:0] br_tgt,
  input  logic            br_tgt_vld,
  output logic            st_taken
);

  // backward (or self) jumps look like loops and are guessed taken
  function automatic logic is_backward(input logic [PC_W-1:0] pc,
                                       input logic [PC_W-1:0] tgt);
    return tgt <= pc;
  endfunction

  assign st_taken = br_tgt_vld && is_backward(br_pc, br_tgt);

endmodule

// File: rtl/bp_hybrid.sv
module bp_hybrid
  import bp_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int DISP_W   = 10,
  parameter int DIR_K    = 6,
  parameter int TB_IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic              lk_disp_vld,
  input  logic [DISP_W-1:0] lk_disp,
  output logic              pred_taken,
  output logic              pred_tgt_vld,
  output logic [PC_W-1:0]   pred_tgt,
  input  logic              upd_en,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [PC_W-1:0]   upd_tgt
);

  localparam int EXT_W = PC_W - DISP_W;

  // pc-relative target with sign extension, wrapping at PC_W bits
  function automatic logic [PC_W-1:0] disp_target(input logic [PC_W-1:0]   pc,
                                                   input logic [DISP_W-1:0] d);
    logic [PC_W-1:0] ext;
    ext = {{EXT_W{d[DISP_W-1]}}, d};
    return pc + ext;
  endfunction

  // ---- direction table ----
  logic dt_vld;
  ctr_t dt_ctr;

  bp_dir_table #(.IDX_W(DIR_K)) u_dir (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (lk_pc[DIR_K-1:0]),
    .rd_vld   (dt_vld),
    .rd_ctr   (dt_ctr),
    .wr_en    (upd_en),
    .wr_idx   (upd_pc[DIR_K-1:0]),
    .wr_taken (upd_taken)
  );

  // ---- target buffer: only taken outcomes are recorded ----
  logic            tb_hit;
  logic [PC_W-1:0] tb_tgt;
  logic            tb_we;

  assign tb_we = upd_en && upd_taken;

  bp_target_buf #(.PC_W(PC_W), .IDX_W(TB_IDX_W)) u_tbuf (
    .clk    (clk),
    .rst    (rst),
    .rd_pc  (lk_pc),
    .rd_hit (tb_hit),
    .rd_tgt (tb_tgt),
    .wr_en  (tb_we),
    .wr_pc  (upd_pc),
    .wr_tgt (upd_tgt)
  );

  // ---- target selection ----
  logic [PC_W-1:0] rel_tgt;
  logic            sel_vld;
  logic [PC_W-1:0] sel_tgt;

  assign rel_tgt = disp_target(lk_pc, lk_disp);
  assign sel_vld = tb_hit || lk_disp_vld;
  assign sel_tgt = tb_hit ? tb_tgt : rel_tgt;

  // ---- static fallback ----
  logic st_taken;

  bp_static_rule #(.PC_W(PC_W)) u_static (
    .br_pc      (lk_pc),
    .br_tgt     (sel_tgt),
    .br_tgt_vld (sel_vld),
    .st_taken   (st_taken)
  );

  // ---- final direction ----
  logic dir_taken;
  assign dir_taken = dt_vld ? ctr_dir(dt_ctr) : st_taken;

  assign pred_taken   = dir_taken && sel_vld;
  assign pred_tgt_vld = sel_vld;
  assign pred_tgt     = sel_vld ? sel_tgt : '0;

  // ---- assertions ----
  a_r9_taken_has_target: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> pred_tgt_vld);

  a_r3_static_forward_not_taken: assert property (@(posedge clk) disable iff (rst)
    (!dt_vld && pred_tgt_vld && (pred_tgt > lk_pc)) |-> !pred_taken);

  a_r2_static_backward_taken: assert property (@(posedge clk) disable iff (rst)
    (!dt_vld && pred_tgt_vld && (pred_tgt <= lk_pc)) |-> pred_taken);

  a_r1_buffer_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !tb_hit);

  a_r8_hit_gives_target: assert property (@(posedge clk) disable iff (rst)
    tb_hit |-> pred_tgt_vld);

endmodule

// File: tb/bp_hybrid_bench.sv
`timescale 1ns/1ps
module bp_hybrid_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] lk_pc = '0;
  logic        lk_disp_vld = 1'b0;
  logic [9:0]  lk_disp = '0;
  logic        pred_taken, pred_tgt_vld;
  logic [15:0] pred_tgt;
  logic        upd_en = 1'b0;
  logic [15:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [15:0] upd_tgt = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bp_hybrid u_bp_hybrid (
    .clk(clk), .rst(rst),
    .lk_pc(lk_pc), .lk_disp_vld(lk_disp_vld), .lk_disp(lk_disp),
    .pred_taken(pred_taken), .pred_tgt_vld(pred_tgt_vld), .pred_tgt(pred_tgt),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_tgt(upd_tgt)
  );

  typedef struct packed {
    logic        ue;
    logic [15:0] upc;
    logic        ut;
    logic [15:0] utg;
    logic [15:0] lpc;
    logic        dv;
    logic [9:0]  d;
    logic        et;
    logic        ev;
    logic [15:0] etg;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h0100,1'b0,10'h000, 1'b0,1'b0,16'h0000, 8'd1},  // R1 nothing known
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h0100,1'b1,10'h3F8, 1'b1,1'b1,16'h00F8, 8'd2},  // R2 backward
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h0100,1'b1,10'h020, 1'b0,1'b1,16'h0120, 8'd3},  // R3 forward
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h0100,1'b1,10'h000, 1'b1,1'b1,16'h0100, 8'd2},  // R2 self
    '{1'b1,16'h0100,1'b1,16'h0200, 16'h0100,1'b1,10'h020, 1'b0,1'b1,16'h0120, 8'd10}, // R10 old view
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h0100,1'b0,10'h000, 1'b1,1'b1,16'h0200, 8'd7},  // R7 hit
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h0100,1'b1,10'h3F8, 1'b1,1'b1,16'h0200, 8'd8},  // R8 buffer wins
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h1100,1'b0,10'h000, 1'b0,1'b0,16'h0000, 8'd9},  // R9 tag miss
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h1100,1'b1,10'h004, 1'b1,1'b1,16'h1104, 8'd11}, // R11 trained fwd
    '{1'b1,16'h0100,1'b1,16'h0200, 16'h0101,1'b1,10'h004, 1'b0,1'b1,16'h0105, 8'd4},  // R4 other index
    '{1'b1,16'h0100,1'b1,16'h0200, 16'h0100,1'b0,10'h000, 1'b1,1'b1,16'h0200, 8'd5},  // R5 at 11
    '{1'b1,16'h0100,1'b0,16'h0000, 16'h0100,1'b0,10'h000, 1'b1,1'b1,16'h0200, 8'd5},  // R5 -> 10
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h0100,1'b0,10'h000, 1'b1,1'b1,16'h0200, 8'd6},  // R6 one miss
    '{1'b1,16'h0100,1'b0,16'h0000, 16'h0100,1'b0,10'h000, 1'b1,1'b1,16'h0200, 8'd6},  // R6 -> 01
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h0100,1'b0,10'h000, 1'b0,1'b1,16'h0200, 8'd6},  // R6 flipped
    '{1'b1,16'h0100,1'b0,16'h0000, 16'h0100,1'b0,10'h000, 1'b0,1'b1,16'h0200, 8'd5},  // R5 -> 00
    '{1'b1,16'h0100,1'b0,16'h0000, 16'h0100,1'b0,10'h000, 1'b0,1'b1,16'h0200, 8'd5},  // R5 hold 00
    '{1'b1,16'h0100,1'b1,16'h0300, 16'h0100,1'b0,10'h000, 1'b0,1'b1,16'h0200, 8'd10}, // R10 -> 01
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h0100,1'b0,10'h000, 1'b0,1'b1,16'h0300, 8'd7},  // R7 new target
    '{1'b1,16'h0140,1'b0,16'h0000, 16'h0100,1'b0,10'h000, 1'b0,1'b1,16'h0300, 8'd7},  // R7 nt no write
    '{1'b1,16'h0140,1'b1,16'h0050, 16'h0100,1'b0,10'h000, 1'b0,1'b1,16'h0300, 8'd4},  // R4 alias 00
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h0100,1'b0,10'h000, 1'b0,1'b0,16'h0000, 8'd7},  // R7 evicted
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h0140,1'b0,10'h000, 1'b0,1'b1,16'h0050, 8'd4},  // R4 shared 01
    '{1'b1,16'h0203,1'b0,16'h0000, 16'h0203,1'b1,10'h3FC, 1'b1,1'b1,16'h01FF, 8'd2},  // R2 before train
    '{1'b0,16'h0000,1'b0,16'h0000, 16'h0203,1'b1,10'h3FC, 1'b0,1'b1,16'h01FF, 8'd11}  // R11 trained 00
  };

  task automatic check1(input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic ue, input logic [15:0] upc, input logic ut,
                      input logic [15:0] utg, input logic [15:0] lpc,
                      input logic dv, input logic [9:0] d,
                      input logic et, input logic ev, input logic [15:0] etg,
                      input string tag);
    @(negedge clk);
    upd_en = ue; upd_pc = upc; upd_taken = ut; upd_tgt = utg;
    lk_pc = lpc; lk_disp_vld = dv; lk_disp = d;
    #2;
    check1(tag, "taken", {15'd0, pred_taken}, {15'd0, et});
    check1(tag, "tgt_vld", {15'd0, pred_tgt_vld}, {15'd0, ev});
    if (ev) check1(tag, "tgt", pred_tgt, etg);
    @(posedge clk);
    #1;
    upd_en = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ue, VEC[i].upc, VEC[i].ut, VEC[i].utg, VEC[i].lpc, VEC[i].dv,
           VEC[i].d, VEC[i].et, VEC[i].ev, VEC[i].etg, $sformatf("R%0d", VEC[i].req));
    end

    // R8 displacement extremes on untrained indices
    step(0, 0, 0, 0, 16'h0105, 1, 10'h1FF, 0, 1, 16'h0304, "R8_R3 max disp");
    step(0, 0, 0, 0, 16'h0405, 1, 10'h200, 1, 1, 16'h0205, "R8_R2 min disp");

    // R6 saturate at 11 then one miss keeps taken
    step(1, 16'h0207, 1, 16'h0100, 16'h0000, 0, 0, 0, 0, 0, "R6 train");
    step(1, 16'h0207, 1, 16'h0100, 16'h0000, 0, 0, 0, 0, 0, "R6 train");
    step(1, 16'h0207, 1, 16'h0100, 16'h0000, 0, 0, 0, 0, 0, "R6 train");
    step(1, 16'h0207, 0, 16'h0000, 16'h0207, 0, 0, 1, 1, 16'h0100, "R6 strong");
    step(0, 0, 0, 0, 16'h0207, 0, 0, 1, 1, 16'h0100, "R6 after one miss");

    // R1 reset in mid-run clears everything learned
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(0, 0, 0, 0, 16'h0140, 0, 0, 0, 0, 0, "R1 buffer cleared");
    step(0, 0, 0, 0, 16'h0207, 0, 0, 0, 0, 0, "R1 buffer cleared 2");
    step(0, 0, 0, 0, 16'h0203, 1, 10'h3FC, 1, 1, 16'h01FF, "R1 counter untrained");
    step(0, 0, 0, 0, 16'h1100, 1, 10'h004, 0, 1, 16'h1104, "R1 static again");

    finish_run();
  end

endmodule